// File: doc/BRIEF.md
# Palette DAC Register Decoder with Hidden-Register Unlock

This block sits between a host microprocessor and a palette DAC that has only two register-select inputs. Those two lines give the host four direct registers: the palette write pointer, the palette data port, the pixel mask and the palette read pointer. The decoder reaches further registers without any new address pins.

The first way in is an unlock sequence. Four reads of the pixel mask in a row open a short window. In that window, each following access to the mask select reaches a hidden register, in a fixed order: the control register, then a vendor code, then a chip code. The window then closes. Once control bit 0 is set, the decoder moves into indexed mode. In indexed mode every access to the mask select goes to an internal register file entry, and the palette write pointer supplies the index. Some registers can only be reached this way: a second control register, a colour-key register and a bank of spare extended registers.

The palette memory itself lies outside the block. The decoder gathers the three colour bytes of a palette write and hands them on as one 24-bit word. For reads, it presents the read pointer and the current colour component to the memory.

Top module: `hxreg_decoder`

## Requirements
- R1: After reset: `rdata` is 0x00, both palette pointers are 0x00, the pixel mask is 0xFF, and control 0, control 1, the colour key and every extended entry are 0x00. Indexed mode is off.
- R2: Select code `rs` maps as follows: 2'b00 is the palette write pointer, 2'b01 is palette data, 2'b10 is the pixel mask and 2'b11 is the palette read pointer. The pointers and the mask can be written and read back. Read data appears on `rdata` in the cycle after the read strobe, and `rdata` holds its value in every cycle without a read.
- R3: While indexed mode is off, exactly four reads of select 2'b10 with no other access between them open the window. The next three accesses to 2'b10 reach control 0, the vendor code and the chip code, in that order. The window then closes, and the following 2'b10 read returns the mask again.
- R4: While the count is below four, any access to another select code clears the unlock count. A write to select 2'b10 also clears it; that write stores the new mask value.
- R5: The vendor code always reads 0x97 and the chip code always reads 0x09. Writes to either one are ignored, whether they come through the window or through an index.
- R6: When control 0 bit 0 is 1, every access to 2'b10 goes to the register at the index held in the write pointer. The index map is: 0 control 0, 1 vendor code, 2 chip code, 3 pixel mask, 4 control 1, 5 colour key, and 6 to 6+N_EXT-1 the extended entries. Any other index reads 0x00 and ignores writes. The ports `ctl0`, `ctl1` and `pix_mask` show the current register contents.
- R7: When control 0 bit 0 is 0, select 2'b10 acts as the plain pixel mask (outside the unlock window). Clearing bit 0 through index 0 returns the block to this behaviour.
- R8: Palette writes take three writes to 2'b01, in the order red, green, blue. In the cycle after the third write, `pal_we` pulses for one cycle with `pal_waddr` set to the pointer value and `pal_wcolor` = {red, green, blue}. The write pointer then increments, wrapping from 0xFF to 0x00. A write to 2'b00 restarts the component count.
- R9: A read of 2'b01 returns `pal_rdata`. The memory is addressed by `pal_raddr` and `pal_rcomp` (component 0, 1 or 2). After the third component read, the read pointer increments and the component count returns to 0.
- R10: The index used in indexed mode is the live write pointer, including any increment caused by palette writes. The index is not shielded from that increment.
- R11: A cycle with `rd_en` and `wr_en` both high is not an access. It changes no register, no counter and `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rs | input | 2 | Register select code |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| pal_rdata | input | 8 | Colour byte from palette memory at `pal_raddr`/`pal_rcomp` |
| pal_raddr | output | 8 | Palette read pointer |
| pal_rcomp | output | 2 | Colour component being read (0 red, 1 green, 2 blue) |
| pal_we | output | 1 | One-cycle palette write pulse |
| pal_waddr | output | 8 | Palette entry written by `pal_we` |
| pal_wcolor | output | 24 | Colour word {red, green, blue} for `pal_we` |
| pix_mask | output | 8 | Current pixel mask |
| ctl0 | output | 8 | Current control 0 register |
| ctl1 | output | 8 | Current control 1 register |

## Verification
The bench breaks the run of mask reads with a read on another select, and separately with a mask write. A design that kept counting across either break would open the window early and return control 0 where the mask is expected. It writes to the vendor code through the window and through an index, and then reads the code back; a decoder that stored those writes would return the written byte instead of the constant. It runs palette writes before an indexed read, so a design that froze the index would return control 1 rather than the colour key. It also drives a cycle with both strobes high, where any design that treated that cycle as an access would move a pointer.

// File: rtl/hxreg_pkg.sv
package hxreg_pkg;

    typedef enum logic [1:0] {
        SEL_WADDR = 2'b00,
        SEL_PDATA = 2'b01,
        SEL_MASK  = 2'b10,
        SEL_RADDR = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        BD_CTL0 = 2'd0,
        BD_MFR  = 2'd1,
        BD_DEV  = 2'd2
    } bd_sel_e;

    localparam logic [7:0] MFR_ID_VAL = 8'h97;
    localparam logic [7:0] DEV_ID_VAL = 8'h09;

    localparam logic [7:0] IDX_CTL0 = 8'd0;
    localparam logic [7:0] IDX_MFR  = 8'd1;
    localparam logic [7:0] IDX_DEV  = 8'd2;
    localparam logic [7:0] IDX_MASK = 8'd3;
    localparam logic [7:0] IDX_CTL1 = 8'd4;
    localparam logic [7:0] IDX_CKEY = 8'd5;
    localparam logic [7:0] IDX_EXT0 = 8'd6;

    localparam logic [7:0] MASK_RST = 8'hFF;

endpackage

// File: rtl/hxreg_unlock.sv
module hxreg_unlock
    import hxreg_pkg::*;
#(
    parameter int UNLOCK_READS = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    acc_vld,
    input  logic    acc_rd,
    input  logic    sel_mask,
    input  logic    idx_mode,
    output logic    bd_hit,
    output bd_sel_e bd_sel
);
    localparam int            CW       = $clog2(UNLOCK_READS + 1);
    localparam logic [CW-1:0] OPEN_CNT = CW'(UNLOCK_READS);
    localparam logic [1:0]    LAST_SUB = 2'd2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    sub;
    } ul_st_t;

    ul_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        bd_hit = 1'b0;
        bd_sel = bd_sel_e'(st_q.sub);
        if (acc_vld) begin
            if (idx_mode || !sel_mask) begin
                // any access elsewhere, or indexed mode, restarts the sequence
                st_d.cnt = '0;
                st_d.sub = '0;
            end else if (st_q.cnt == OPEN_CNT) begin
                bd_hit = 1'b1;
                if (st_q.sub == LAST_SUB) begin
                    st_d.cnt = '0;
                    st_d.sub = '0;
                end else begin
                    st_d.sub = st_q.sub + 2'd1;
                end
            end else if (acc_rd) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/hxreg_palseq.sv
module hxreg_palseq
    import hxreg_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_vld,
    input  logic            acc_rd,
    input  sel_e            sel,
    input  logic [DW-1:0]   wdata,
    output logic [AW-1:0]   waddr,
    output logic [AW-1:0]   raddr,
    output logic [1:0]      rcomp,
    output logic            pal_we,
    output logic [AW-1:0]   pal_waddr,
    output logic [3*DW-1:0] pal_wcolor
);
    localparam logic [1:0] LAST_COMP = 2'd2;

    typedef struct packed {
        logic [AW-1:0]   waddr;
        logic [AW-1:0]   raddr;
        logic [1:0]      wcomp;
        logic [1:0]      rcomp;
        logic [2*DW-1:0] stage;
        logic            we;
        logic [AW-1:0]   we_addr;
        logic [3*DW-1:0] we_color;
    } ps_st_t;

    ps_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (acc_vld) begin
            unique case (sel)
                SEL_WADDR: begin
                    if (!acc_rd) begin
                        st_d.waddr = wdata;
                        st_d.wcomp = '0;
                    end
                end
                SEL_RADDR: begin
                    if (!acc_rd) begin
                        st_d.raddr = wdata;
                        st_d.rcomp = '0;
                    end
                end
                SEL_PDATA: begin
                    if (!acc_rd) begin
                        if (st_q.wcomp == LAST_COMP) begin
                            st_d.we       = 1'b1;
                            st_d.we_addr  = st_q.waddr;
                            st_d.we_color = {st_q.stage, wdata};
                            st_d.waddr    = st_q.waddr + 1'b1;
                            st_d.wcomp    = '0;
                        end else begin
                            st_d.stage = {st_q.stage[DW-1:0], wdata};
                            st_d.wcomp = st_q.wcomp + 2'd1;
                        end
                    end else begin
                        if (st_q.rcomp == LAST_COMP) begin
                            st_d.raddr = st_q.raddr + 1'b1;
                            st_d.rcomp = '0;
                        end else begin
                            st_d.rcomp = st_q.rcomp + 2'd1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign waddr      = st_q.waddr;
    assign raddr      = st_q.raddr;
    assign rcomp      = st_q.rcomp;
    assign pal_we     = st_q.we;
    assign pal_waddr  = st_q.we_addr;
    assign pal_wcolor = st_q.we_color;

endmodule

// File: rtl/hxreg_file.sv
module hxreg_file
    import hxreg_pkg::*;
#(
    parameter int N_EXT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rval,
    output logic [7:0] ctl0,
    output logic [7:0] ctl1,
    output logic [7:0] mask
);
    typedef struct packed {
        logic [7:0]            ctl0;
        logic [7:0]            ctl1;
        logic [7:0]            ckey;
        logic [7:0]            mask;
        logic [N_EXT-1:0][7:0] ext;
    } rf_st_t;

    rf_st_t      rf_d, rf_q;
    logic [N_EXT-1:0] ext_hit;

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext_hit
        assign ext_hit[g] = (idx == 8'(IDX_EXT0 + g));
    end

    always_comb begin
        rf_d = rf_q;
        if (we) begin
            if (idx == IDX_CTL0) begin
                rf_d.ctl0 = wdata;
            end else if (idx == IDX_MASK) begin
                rf_d.mask = wdata;
            end else if (idx == IDX_CTL1) begin
                rf_d.ctl1 = wdata;
            end else if (idx == IDX_CKEY) begin
                rf_d.ckey = wdata;
            end
            for (int k = 0; k < N_EXT; k++) begin
                if (ext_hit[k]) begin
                    rf_d.ext[k] = wdata;
                end
            end
        end
    end

    always_comb begin
        rval = '0;
        if (idx == IDX_CTL0) begin
            rval = rf_q.ctl0;
        end else if (idx == IDX_MFR) begin
            rval = MFR_ID_VAL;
        end else if (idx == IDX_DEV) begin
            rval = DEV_ID_VAL;
        end else if (idx == IDX_MASK) begin
            rval = rf_q.mask;
        end else if (idx == IDX_CTL1) begin
            rval = rf_q.ctl1;
        end else if (idx == IDX_CKEY) begin
            rval = rf_q.ckey;
        end
        for (int k = 0; k < N_EXT; k++) begin
            if (ext_hit[k]) begin
                rval = rf_q.ext[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q      <= '0;
            rf_q.mask <= MASK_RST;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign ctl0 = rf_q.ctl0;
    assign ctl1 = rf_q.ctl1;
    assign mask = rf_q.mask;

endmodule

// File: rtl/hxreg_decoder.sv
module hxreg_decoder
    import hxreg_pkg::*;
#(
    parameter int UNLOCK_READS = 4,
    parameter int N_EXT        = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  rs,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [7:0]  pal_rdata,
    output logic [7:0]  pal_raddr,
    output logic [1:0]  pal_rcomp,
    output logic        pal_we,
    output logic [7:0]  pal_waddr,
    output logic [23:0] pal_wcolor,
    output logic [7:0]  pix_mask,
    output logic [7:0]  ctl0,
    output logic [7:0]  ctl1
);
    typedef struct packed {
        logic [7:0] rdata;
    } dec_st_t;

    dec_st_t st_d, st_q;

    logic       acc_vld;
    logic       acc_rd;
    sel_e       sel;
    logic       sel_mask;
    logic       idx_mode;
    logic       bd_hit_w;
    bd_sel_e    bd_sel_w;
    logic [7:0] waddr_w;
    logic [7:0] raddr_w;
    logic [7:0] file_idx;
    logic       file_we;
    logic [7:0] file_rval;

    // both strobes together are not an access
    assign acc_vld  = rd_en ^ wr_en;
    assign acc_rd   = rd_en & ~wr_en;
    assign sel      = sel_e'(rs);
    assign sel_mask = (sel == SEL_MASK);
    assign idx_mode = ctl0[0];

    hxreg_unlock #(
        .UNLOCK_READS(UNLOCK_READS)
    ) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_vld  (acc_vld),
        .acc_rd   (acc_rd),
        .sel_mask (sel_mask),
        .idx_mode (idx_mode),
        .bd_hit   (bd_hit_w),
        .bd_sel   (bd_sel_w)
    );

    hxreg_palseq #(
        .AW(8),
        .DW(8)
    ) u_palseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_vld    (acc_vld),
        .acc_rd     (acc_rd),
        .sel        (sel),
        .wdata      (wdata),
        .waddr      (waddr_w),
        .raddr      (raddr_w),
        .rcomp      (pal_rcomp),
        .pal_we     (pal_we),
        .pal_waddr  (pal_waddr),
        .pal_wcolor (pal_wcolor)
    );

    always_comb begin
        if (idx_mode) begin
            file_idx = waddr_w;
        end else if (bd_hit_w) begin
            file_idx = {6'd0, bd_sel_w};
        end else begin
            file_idx = IDX_MASK;
        end
    end

    assign file_we = acc_vld & ~acc_rd & sel_mask;

    hxreg_file #(
        .N_EXT(N_EXT)
    ) u_file (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (file_we),
        .idx   (file_idx),
        .wdata (wdata),
        .rval  (file_rval),
        .ctl0  (ctl0),
        .ctl1  (ctl1),
        .mask  (pix_mask)
    );

    always_comb begin
        st_d = st_q;
        if (acc_rd) begin
            unique case (sel)
                SEL_WADDR: st_d.rdata = waddr_w;
                SEL_PDATA: st_d.rdata = pal_rdata;
                SEL_MASK:  st_d.rdata = file_rval;
                SEL_RADDR: st_d.rdata = raddr_w;
                default:   st_d.rdata = st_q.rdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata     = st_q.rdata;
    assign pal_raddr = raddr_w;

endmodule

// File: rtl/hxreg_decoder_chk.sv
module hxreg_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rs,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] rdata,
    input logic       pal_we,
    input logic [7:0] pal_raddr,
    input logic [1:0] pal_rcomp,
    input logic [7:0] pix_mask,
    input logic [7:0] ctl0,
    input logic [7:0] waddr,
    input logic       bd_hit
);
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> $stable(rdata)); // R2

    AST_MFR_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && rs == 2'b10 && ctl0[0] && waddr == 8'h01) |=> (rdata == 8'h97)); // R5

    AST_CTL0_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl0) |-> $past(wr_en && !rd_en && rs == 2'b10)); // R6

    AST_PLAIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && rs == 2'b10 && !ctl0[0] && !bd_hit) |=> (rdata == $past(pix_mask))); // R7

    AST_PWE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |=> !pal_we); // R8

    AST_BOTH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> ($stable(pix_mask) && $stable(ctl0) && $stable(waddr)
                              && $stable(pal_raddr) && $stable(pal_rcomp))); // R11
endmodule

bind hxreg_decoder hxreg_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rs        (rs),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .rdata     (rdata),
    .pal_we    (pal_we),
    .pal_raddr (pal_raddr),
    .pal_rcomp (pal_rcomp),
    .pix_mask  (pix_mask),
    .ctl0      (ctl0),
    .waddr     (waddr_w),
    .bd_hit    (bd_hit_w)
);

// File: tb/hxreg_decoder_tb.sv
module hxreg_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rs = 2'b00;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [7:0]  pal_rdata;
    logic [7:0]  pal_raddr;
    logic [1:0]  pal_rcomp;
    logic        pal_we;
    logic [7:0]  pal_waddr;
    logic [23:0] pal_wcolor;
    logic [7:0]  pix_mask;
    logic [7:0]  ctl0;
    logic [7:0]  ctl1;

    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb_q[$];
    logic rd_seen = 1'b0;

    always #10 clk = ~clk;

    // palette memory model: byte = address + 0x40 * component
    assign pal_rdata = pal_raddr + {pal_rcomp, 6'd0};

    hxreg_decoder #(
        .UNLOCK_READS(4),
        .N_EXT(8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rs(rs), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .pal_rdata(pal_rdata),
        .pal_raddr(pal_raddr), .pal_rcomp(pal_rcomp), .pal_we(pal_we),
        .pal_waddr(pal_waddr), .pal_wcolor(pal_wcolor), .pix_mask(pix_mask),
        .ctl0(ctl0), .ctl1(ctl1)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item for each read the design accepted
    always @(posedge clk) rd_seen <= rst_n && rd_en && !wr_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                check("scoreboard underflow", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, {24'd0, rdata}, {24'd0, e.val});
            end
        end
    end

    task automatic access(input logic [1:0] r, input logic rd, input logic wr, input logic [7:0] d);
        @(negedge clk);
        rs = r; rd_en = rd; wr_en = wr; wdata = d;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] r, input logic [7:0] d);
        access(r, 1'b0, 1'b1, d);
    endtask

    task automatic rd(input logic [1:0] r, input logic [7:0] e, input string tag);
        exp_t it;
        it.val = e; it.tag = tag;
        sb_q.push_back(it);
        access(r, 1'b1, 1'b0, 8'h00);
    endtask

    task automatic unlock(input logic [7:0] m);
        for (int i = 0; i < 4; i++) rd(2'b10, m, "R3 counting read");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", {24'd0, rdata}, 32'h00);
        check("R1 mask", {24'd0, pix_mask}, 32'hFF);
        check("R1 ctl0", {24'd0, ctl0}, 32'h00);
        check("R1 ctl1", {24'd0, ctl1}, 32'h00);
        check("R1 pal_we", {31'd0, pal_we}, 32'd0);
        rd(2'b00, 8'h00, "R1 write pointer");

        // R2 direct registers
        wr(2'b00, 8'h34); rd(2'b00, 8'h34, "R2 write pointer");
        wr(2'b11, 8'h56); rd(2'b11, 8'h56, "R2 read pointer");
        wr(2'b10, 8'hC3); rd(2'b10, 8'hC3, "R2 mask");
        check("R2 pix_mask", {24'd0, pix_mask}, 32'hC3);

        // R4 break by another select, then R3 full unlock
        rd(2'b00, 8'h34, "R4 break");
        for (int i = 0; i < 3; i++) rd(2'b10, 8'hC3, "R4 partial run");
        rd(2'b00, 8'h34, "R4 break");
        for (int i = 0; i < 4; i++) rd(2'b10, 8'hC3, "R4 count restarted");
        rd(2'b10, 8'h00, "R3 window ctl0");
        rd(2'b10, 8'h97, "R3 window vendor code");
        rd(2'b10, 8'h09, "R3 window chip code");
        rd(2'b10, 8'hC3, "R3 window closed");

        // R4 mask write clears the count
        rd(2'b00, 8'h34, "R4 break");
        for (int i = 0; i < 3; i++) rd(2'b10, 8'hC3, "R4 partial run");
        wr(2'b10, 8'h5A);
        for (int i = 0; i < 4; i++) rd(2'b10, 8'h5A, "R4 count after mask write");
        rd(2'b10, 8'h00, "R4 window after restart");
        rd(2'b00, 8'h34, "R4 close");

        // R5 id writes ignored through the window
        unlock(8'h5A);
        wr(2'b10, 8'h02);
        wr(2'b10, 8'hAA);
        rd(2'b10, 8'h09, "R5 chip code");
        check("R5 ctl0 via window", {24'd0, ctl0}, 32'h02);
        unlock(8'h5A);
        rd(2'b10, 8'h02, "R3 ctl0 readback");
        rd(2'b10, 8'h97, "R5 vendor code after write");
        rd(2'b00, 8'h34, "R3 close");

        // R6 indexed mode
        unlock(8'h5A);
        wr(2'b10, 8'h03);
        check("R6 ctl0 enable", {24'd0, ctl0}, 32'h03);
        wr(2'b00, 8'h04); wr(2'b10, 8'h3C);
        wr(2'b00, 8'h04); rd(2'b10, 8'h3C, "R6 ctl1");
        check("R6 ctl1 port", {24'd0, ctl1}, 32'h3C);
        wr(2'b00, 8'h06); wr(2'b10, 8'h11);
        wr(2'b00, 8'h0D); wr(2'b10, 8'hEE);
        wr(2'b00, 8'h06); rd(2'b10, 8'h11, "R6 first extended");
        wr(2'b00, 8'h0D); rd(2'b10, 8'hEE, "R6 last extended");
        wr(2'b00, 8'h0E); wr(2'b10, 8'h77);
        wr(2'b00, 8'h0E); rd(2'b10, 8'h00, "R6 unmapped index");
        wr(2'b00, 8'h03); rd(2'b10, 8'h5A, "R6 mask by index");
        wr(2'b00, 8'h03); wr(2'b10, 8'h0F);
        check("R6 mask port", {24'd0, pix_mask}, 32'h0F);
        wr(2'b00, 8'h01); wr(2'b10, 8'h00);
        wr(2'b00, 8'h01); rd(2'b10, 8'h97, "R5 vendor code by index");
        wr(2'b00, 8'h02); rd(2'b10, 8'h09, "R5 chip code by index");

        // R8 and R10 palette write moves the index
        wr(2'b00, 8'h04);
        wr(2'b01, 8'h11); wr(2'b01, 8'h22); wr(2'b01, 8'h33);
        check("R8 pal_we", {31'd0, pal_we}, 32'd1);
        check("R8 pal_waddr", {24'd0, pal_waddr}, 32'h04);
        check("R8 pal_wcolor", {8'd0, pal_wcolor}, 32'h112233);
        rd(2'b00, 8'h05, "R8 pointer increment");
        rd(2'b10, 8'h00, "R10 index follows increment");

        // R8 component restart and wrap
        wr(2'b00, 8'h10); wr(2'b01, 8'hAA);
        wr(2'b00, 8'h20);
        wr(2'b01, 8'h01); wr(2'b01, 8'h02); wr(2'b01, 8'h03);
        check("R8 restart addr", {24'd0, pal_waddr}, 32'h20);
        check("R8 restart color", {8'd0, pal_wcolor}, 32'h010203);
        wr(2'b00, 8'hFF);
        wr(2'b01, 8'h07); wr(2'b01, 8'h08); wr(2'b01, 8'h09);
        check("R8 wrap addr", {24'd0, pal_waddr}, 32'hFF);
        rd(2'b00, 8'h00, "R8 wrap pointer");

        // R9 palette reads
        wr(2'b11, 8'h20);
        rd(2'b01, 8'h20, "R9 red");
        rd(2'b01, 8'h60, "R9 green");
        rd(2'b01, 8'hA0, "R9 blue");
        rd(2'b11, 8'h21, "R9 read pointer increment");
        rd(2'b01, 8'h21, "R9 next entry");

        // R11 both strobes
        access(2'b00, 1'b1, 1'b1, 8'h77);
        rd(2'b00, 8'h00, "R11 pointer unchanged");
        check("R11 rdata unchanged", {24'd0, rdata}, 32'h00);

        // R7 leave indexed mode
        wr(2'b00, 8'h00); wr(2'b10, 8'h00);
        check("R7 ctl0 cleared", {24'd0, ctl0}, 32'h00);
        rd(2'b10, 8'h0F, "R7 plain mask");

        @(negedge clk);
        check("scoreboard drained", sb_q.size(), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule